// File: doc/BRIEF.md
# Address-Event Grid Relay Node

This block sits on every chip of a chain of spiking-neuron chips and moves address-events from one chip to the next. Each event is a header word followed by zero or more payload words (the row and column of the firing neuron). Events that arrive from the upstream neighbour are re-sent to the downstream neighbour, and events produced by the chip's own neuron array are injected into the same downstream stream. Because every chip passes traffic on over its own link, adding chips adds links instead of sharing one bus.

The header carries two hop fields that the node rewrites as the event passes. The age field counts links crossed, so a receiver can work out which chip sent the event without any per-chip address setting. The target field counts the links still to go before the addressed chip. The node uses the mode bits and the target field to decide whether to hand the event to its own core. Oblivious events go to every chip. Targeted events go only to the chip where the target field arrives as zero. Excluded events go to every chip except that one. A copy handed to the core keeps the same row and column as the sender, so neurons connect point to point.

Upstream traffic and local injection share the downstream link through a round-robin arbiter. A grant lasts for a whole event, so the words of one event are never split up. All four ports use valid/ready handshakes.

Top module: `aer_grid_relay`

## Requirements
- R1: During reset and on the first cycle after it, `dn_valid`, `loc_valid`, `up_ready` and `inj_ready` are low.
- R2: A word moves only on a cycle where its valid and ready are both high. Words held back by a low `dn_ready` or `loc_ready` are neither lost, duplicated nor reordered. An output word stays stable while it waits.
- R3: Word format: bit WORD_W-1 of every word is the last-word flag. In a header, bits [1:0] hold the mode, bits [HOP_W+1:2] hold the age and bits [2*HOP_W+1:HOP_W+2] hold the target, where HOP_W = clog2(MAX_HOPS+1). An upstream event that is forwarded leaves with age+1 and target-1 (modulo 2^HOP_W). All its other header bits and all payload words are unchanged.
- R4: For an injected event, the age bits supplied by the local core are ignored. The event leaves downstream with age 1 and its target field decremented by one. It is never handed to the local core.
- R5: Mode 00 (oblivious): an upstream event is handed to the local core and also forwarded.
- R6: Mode 01 (targeted): an upstream event is handed to the local core only when its target field arrives as 0. In that case it is not forwarded. Otherwise it is forwarded and not delivered.
- R7: Mode 10 (excluded): an upstream event is handed to the local core only when its target field arrives as non-zero. It is forwarded in both cases.
- R8: An upstream event whose arriving age is MAX_HOPS or more is not forwarded. Its local delivery still follows R5 to R7. Every forwarded header has an age from 1 to MAX_HOPS.
- R9: The words of one event leave downstream back to back from a single source. No word of another event falls between its header and its last word.
- R10: When both sources have an event waiting, downstream grants alternate between upstream traffic and injection, one event at a time.
- R11: Mode 11 is reserved. Such an event, from either source, is consumed and then dropped: nothing of it appears on `dn_*` or `loc_*`.
- R12: The words handed to the local core are the arriving words exactly, with the header's age and target fields not rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_valid | input | 1 | Upstream word valid |
| up_ready | output | 1 | Upstream word accepted |
| up_data | input | WORD_W | Upstream word |
| inj_valid | input | 1 | Local injection word valid |
| inj_ready | output | 1 | Local injection word accepted |
| inj_data | input | WORD_W | Local injection word |
| dn_valid | output | 1 | Downstream word valid |
| dn_ready | input | 1 | Downstream neighbour can take a word |
| dn_data | output | WORD_W | Downstream word |
| loc_valid | output | 1 | Word for the local core valid |
| loc_ready | input | 1 | Local core can take a word |
| loc_data | output | WORD_W | Word for the local core |

## Verification
The bench builds the node with WORD_W = 12 and MAX_HOPS = 6. This gives 3-bit age and target fields, so the age limit can be hit by driving an arriving age of 6, and a target of 0 wraps to 7 when an excluded event is forwarded. The narrow fields keep every mode/target-hit/age-limit combination small enough to drive by hand. The mixed-traffic phase uses pseudo-random backpressure on both outputs so that stalls land on headers and payload words alike. The fairness phase keeps both sources loaded with equal backlogs, so the order of grants can be predicted exactly.

// File: rtl/aer_relay_pkg.sv
// Shared definitions for the address-event relay node.
// Assumes the mode occupies bits [1:0] of every header word.
package aer_relay_pkg;

    typedef enum logic [1:0] {
        MODE_ALL  = 2'b00,   // deliver on every chip
        MODE_ONE  = 2'b01,   // deliver only where target arrives as zero
        MODE_BUT  = 2'b10,   // deliver everywhere except that chip
        MODE_RSV  = 2'b11    // reserved, dropped
    } dlv_mode_e;

endpackage

// File: rtl/aer_hdr_rule.sv
// Header rule: decides forwarding and local delivery for one header word
// and produces the rewritten header for the downstream link.
// Assumes the word given is a header; the caller ignores outputs otherwise.
module aer_hdr_rule
    import aer_relay_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int HOP_W    = 3,
    parameter int MAX_HOPS = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic              from_local,
    output logic              fwd,
    output logic              dlv,
    output logic [WORD_W-1:0] hdr_out
);
    localparam int AGE_LO = 2;
    localparam int TGT_LO = AGE_LO + HOP_W;

    dlv_mode_e        mode;
    logic [HOP_W-1:0] age;
    logic [HOP_W-1:0] tgt;
    logic             hit;
    logic             young;

    // Decode fields, apply the delivery table and rewrite the hop fields.
    always_comb begin
        mode  = dlv_mode_e'(word[1:0]);
        age   = from_local ? '0 : word[AGE_LO +: HOP_W];
        tgt   = word[TGT_LO +: HOP_W];
        hit   = (tgt == '0);
        young = (age < HOP_W'(MAX_HOPS));
        case (mode)
            MODE_ALL: begin fwd = young;                       dlv = 1'b1; end
            MODE_ONE: begin fwd = young && (from_local || !hit); dlv = hit;  end
            MODE_BUT: begin fwd = young;                       dlv = !hit; end
            default:  begin fwd = 1'b0;                        dlv = 1'b0; end
        endcase
        if (from_local) dlv = 1'b0;
        hdr_out = word;
        hdr_out[AGE_LO +: HOP_W] = age + HOP_W'(1);
        hdr_out[TGT_LO +: HOP_W] = tgt - HOP_W'(1);
    end

endmodule

// File: rtl/aer_evt_arb.sv
// Event-grained round-robin arbiter between two word streams.
// A grant is taken when idle and held until the owner's last word moves.
// Assumes req[0] is upstream traffic and req[1] is local injection.
module aer_evt_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       done,
    output logic [1:0] gnt
);
    logic       last_q;   // 1 when injection held the most recent grant
    logic [1:0] pick;

    // Choose the source that did not win last when both are waiting.
    always_comb begin
        if (req == 2'b11) pick = last_q ? 2'b01 : 2'b10;
        else              pick = req;
    end

    // Hold the grant for a whole event, then fall idle for re-arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt    <= '0;
            last_q <= 1'b1;
        end else if (gnt != '0) begin
            if (done) gnt <= '0;
        end else if (req != '0) begin
            gnt    <= pick;
            last_q <= pick[1];
        end
    end

endmodule

// File: rtl/aer_hold_reg.sv
// One-word output register with valid/ready on both sides.
// Assumes the consumer may hold ready low for any number of cycles.
module aer_hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // Room exists when empty or when the held word leaves this cycle.
    always_comb in_ready = !out_valid || out_ready;

    // Load a new word or drain the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/aer_grid_relay.sv
// Relay node: merges upstream and local events onto the downstream link,
// rewrites hop fields and filters delivery to the local core.
// Assumes every event ends with a word whose top bit is set and that an
// injected targeted event carries a target distance of at least one.
module aer_grid_relay
    import aer_relay_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int MAX_HOPS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [WORD_W-1:0] up_data,
    input  logic              inj_valid,
    output logic              inj_ready,
    input  logic [WORD_W-1:0] inj_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [WORD_W-1:0] dn_data,
    output logic              loc_valid,
    input  logic              loc_ready,
    output logic [WORD_W-1:0] loc_data
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    logic [1:0]        gnt;
    logic              evt_done;
    logic              src_valid;
    logic [WORD_W-1:0] src_word;
    logic              rule_fwd, rule_dlv;
    logic [WORD_W-1:0] hdr_new;
    logic              first_q, fwd_q, dlv_q;
    logic              fwd_eff, dlv_eff;
    logic              dn_in_ready, loc_in_ready;
    logic              dn_room, loc_room, take;
    logic              dn_in_valid, loc_in_valid;
    logic [WORD_W-1:0] dn_in_word;

    aer_evt_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({inj_valid, up_valid}),
        .done  (evt_done),
        .gnt   (gnt)
    );

    aer_hdr_rule #(.WORD_W(WORD_W), .HOP_W(HOP_W), .MAX_HOPS(MAX_HOPS)) u_rule (
        .word       (src_word),
        .from_local (gnt[1]),
        .fwd        (rule_fwd),
        .dlv        (rule_dlv),
        .hdr_out    (hdr_new)
    );

    // Select the granted source and route its current word.
    always_comb begin
        src_valid    = gnt[0] ? up_valid : (gnt[1] ? inj_valid : 1'b0);
        src_word     = gnt[1] ? inj_data : up_data;
        fwd_eff      = first_q ? rule_fwd : fwd_q;
        dlv_eff      = first_q ? rule_dlv : dlv_q;
        dn_room      = !fwd_eff || dn_in_ready;
        loc_room     = !dlv_eff || loc_in_ready;
        take         = src_valid && dn_room && loc_room;
        up_ready     = gnt[0] && dn_room && loc_room;
        inj_ready    = gnt[1] && dn_room && loc_room;
        dn_in_valid  = src_valid && fwd_eff && loc_room;
        loc_in_valid = src_valid && dlv_eff && dn_room;
        dn_in_word   = first_q ? hdr_new : src_word;
        evt_done     = take && src_word[WORD_W-1];
    end

    // Remember the header's routing for the payload words of the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            fwd_q   <= 1'b0;
            dlv_q   <= 1'b0;
        end else if (take) begin
            first_q <= src_word[WORD_W-1];
            if (first_q) begin
                fwd_q <= rule_fwd;
                dlv_q <= rule_dlv;
            end
        end
    end

    aer_hold_reg #(.W(WORD_W)) u_dn_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dn_in_valid),
        .in_ready  (dn_in_ready),
        .in_data   (dn_in_word),
        .out_valid (dn_valid),
        .out_ready (dn_ready),
        .out_data  (dn_data)
    );

    aer_hold_reg #(.W(WORD_W)) u_loc_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (loc_in_valid),
        .in_ready  (loc_in_ready),
        .in_data   (src_word),
        .out_valid (loc_valid),
        .out_ready (loc_ready),
        .out_data  (loc_data)
    );

endmodule

// File: rtl/aer_grid_relay_chk.sv
// Port-level checker for the relay node, attached by bind.
// Tracks header position on each output from its own handshakes.
module aer_grid_relay_chk #(
    parameter int WORD_W   = 12,
    parameter int MAX_HOPS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_ready,
    input logic              inj_ready,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [WORD_W-1:0] dn_data,
    input logic              loc_valid,
    input logic              loc_ready,
    input logic [WORD_W-1:0] loc_data
);
    localparam int HOP_W  = $clog2(MAX_HOPS + 1);
    localparam int AGE_LO = 2;
    localparam int TGT_LO = AGE_LO + HOP_W;

    logic dn_at_hdr, loc_at_hdr;

    // Follow event boundaries on each output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_at_hdr  <= 1'b1;
            loc_at_hdr <= 1'b1;
        end else begin
            if (dn_valid && dn_ready)   dn_at_hdr  <= dn_data[WORD_W-1];
            if (loc_valid && loc_ready) loc_at_hdr <= loc_data[WORD_W-1];
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dn_valid && !loc_valid && !up_ready && !inj_ready);

    p_dn_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

    p_loc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && !loc_ready |=> loc_valid && $stable(loc_data));

    p_one_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_ready, inj_ready}));

    p_age_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_at_hdr |->
            dn_data[AGE_LO +: HOP_W] != '0 &&
            dn_data[AGE_LO +: HOP_W] <= HOP_W'(MAX_HOPS));

    p_dn_no_rsv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_at_hdr |-> dn_data[1:0] != 2'b11);

    p_loc_no_rsv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && loc_at_hdr |-> loc_data[1:0] != 2'b11);

    p_tgt_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && loc_at_hdr && loc_data[1:0] == 2'b01 |->
            loc_data[TGT_LO +: HOP_W] == '0);

    p_exc_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && loc_at_hdr && loc_data[1:0] == 2'b10 |->
            loc_data[TGT_LO +: HOP_W] != '0);

endmodule

bind aer_grid_relay aer_grid_relay_chk #(.WORD_W(WORD_W), .MAX_HOPS(MAX_HOPS)) u_chk (.*);

// File: tb/sim_aer_grid_relay.sv
// Scoreboard bench: driver tasks queue expected words, monitors compare.
module sim_aer_grid_relay;
    localparam int W    = 12;
    localparam int MAXH = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_valid = 1'b0, inj_valid = 1'b0;
    logic [W-1:0] up_data = '0, inj_data = '0;
    logic         up_ready, inj_ready, dn_valid, loc_valid;
    logic         dn_ready = 1'b1, loc_ready = 1'b1;
    logic [W-1:0] dn_data, loc_data;

    always #2 clk = ~clk;   // 250 MHz

    aer_grid_relay #(.WORD_W(W), .MAX_HOPS(MAXH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_data(loc_data)
    );

    int total = 0, bad = 0;
    logic [W-1:0] q_dn_up[$], q_dn_inj[$], q_loc[$];
    string        t_dn_up[$], t_dn_inj[$], t_loc[$];
    bit           bp_en = 1'b0, log_on = 1'b0;
    int           src_log[$];
    logic [7:0]   lfsr = 8'h5a;

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk_hdr(int mode, int age, int tgt, bit last);
        mk_hdr = {last, 3'b000, 3'(tgt), 3'(age), 2'(mode)};
    endfunction

    function automatic logic [W-1:0] mk_pay(int seed, int i, bit last);
        mk_pay = {last, 11'((seed * 13 + i * 7 + 3) % 2048)};
    endfunction

    // Backpressure source: pseudo-random when enabled, else always ready.
    always @(negedge clk) begin
        if (bp_en) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            dn_ready  = lfsr[0] | lfsr[3];
            loc_ready = lfsr[1] | lfsr[6];
        end else begin
            dn_ready  = 1'b1;
            loc_ready = 1'b1;
        end
    end

    // Upstream driver; expected words follow R3 and R5-R8, R11, R12.
    task automatic send_up(int mode, int age, int tgt, int npay, int seed, string tag);
        bit hit = (tgt == 0);
        bit dlv = (mode == 0) || (mode == 1 && hit) || (mode == 2 && !hit);
        bit fwd = (mode != 3) && (age < MAXH) && !(mode == 1 && hit);
        logic [W-1:0] w;
        for (int i = 0; i <= npay; i++) begin
            w = (i == 0) ? mk_hdr(mode, age, tgt, npay == 0) : mk_pay(seed, i, i == npay);
            if (fwd) begin
                q_dn_up.push_back((i == 0) ? mk_hdr(mode, age + 1, (tgt + 7) % 8, npay == 0) : w);
                t_dn_up.push_back(tag);
            end
            if (dlv) begin
                q_loc.push_back(w);
                t_loc.push_back(tag);
            end
        end
        for (int i = 0; i <= npay; i++) begin
            up_data  = (i == 0) ? mk_hdr(mode, age, tgt, npay == 0) : mk_pay(seed, i, i == npay);
            up_valid = 1'b1;
            #1;
            while (!up_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        up_valid = 1'b0;
    endtask

    // Injection driver; junk age bits are supplied to exercise R4.
    task automatic send_inj(int mode, int junk, int tgt, int npay, int seed, string tag);
        for (int i = 0; i <= npay; i++) begin
            if (mode != 3) begin
                q_dn_inj.push_back((i == 0) ? mk_hdr(mode, 1, (tgt + 7) % 8, npay == 0)
                                            : mk_pay(seed, i, i == npay));
                t_dn_inj.push_back(tag);
            end
        end
        for (int i = 0; i <= npay; i++) begin
            inj_data  = (i == 0) ? mk_hdr(mode, junk, tgt, npay == 0) : mk_pay(seed, i, i == npay);
            inj_valid = 1'b1;
            #1;
            while (!inj_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        inj_valid = 1'b0;
    endtask

    // Downstream monitor: header age 1 marks an injected event (R4, R9).
    bit dn_hdr = 1'b1, dn_src_inj = 1'b0;
    always @(negedge clk) begin
        #1;
        if (rst_n && dn_valid && dn_ready) begin
            if (dn_hdr) begin
                dn_src_inj = (dn_data[4:2] == 3'd1);
                if (log_on) src_log.push_back(int'(dn_src_inj));
            end
            if (dn_src_inj) begin
                if (q_dn_inj.size() == 0) check(1'b0, "R11 unexpected dn word", dn_data, '0);
                else check(dn_data == q_dn_inj[0], {t_dn_inj[0], " R9 dn"}, dn_data, q_dn_inj[0]);
                if (q_dn_inj.size() != 0) begin void'(q_dn_inj.pop_front()); void'(t_dn_inj.pop_front()); end
            end else begin
                if (q_dn_up.size() == 0) check(1'b0, "R11 unexpected dn word", dn_data, '0);
                else check(dn_data == q_dn_up[0], {t_dn_up[0], " R9 dn"}, dn_data, q_dn_up[0]);
                if (q_dn_up.size() != 0) begin void'(q_dn_up.pop_front()); void'(t_dn_up.pop_front()); end
            end
            dn_hdr = dn_data[W-1];
        end
    end

    // Local-core monitor (R12 words unchanged).
    always @(negedge clk) begin
        #1;
        if (rst_n && loc_valid && loc_ready) begin
            if (q_loc.size() == 0) check(1'b0, "R4 unexpected loc word", loc_data, '0);
            else begin
                check(loc_data == q_loc[0], {t_loc[0], " R12 loc"}, loc_data, q_loc[0]);
                void'(q_loc.pop_front());
                void'(t_loc.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check({up_ready, inj_ready, dn_valid, loc_valid} == 4'b0, "R1 in reset", W'(0), W'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check({up_ready, inj_ready, dn_valid, loc_valid} == 4'b0, "R1 after reset",
              W'({up_ready, inj_ready, dn_valid, loc_valid}), W'(0));
        @(negedge clk);

        send_up(0, 1, 0, 2, 1, "R5 oblivious");          // R3 R5 R12
        send_up(1, 2, 0, 2, 2, "R6 target hit");         // delivered only
        send_up(1, 1, 2, 1, 3, "R6 target miss");        // forwarded only
        send_up(1, 3, 0, 0, 4, "R6 header-only hit");
        send_up(2, 1, 0, 2, 5, "R7 excluded hit");       // forwarded, tgt wraps
        send_up(2, 2, 3, 2, 6, "R7 excluded miss");      // both
        send_up(0, 6, 1, 2, 7, "R8 age limit");          // delivered only
        send_up(0, 5, 1, 1, 8, "R8 below limit");
        send_up(3, 1, 0, 2, 9, "R11 reserved up");       // dropped
        send_inj(3, 0, 1, 2, 10, "R11 reserved inj");    // dropped
        send_inj(0, 5, 2, 2, 11, "R4 inject");           // age forced to 1
        send_inj(1, 7, 3, 1, 12, "R4 inject targeted");
        send_up(0, 1, 4, 1, 13, "R5 after reserved");

        bp_en = 1'b1;                                     // R2 backpressure
        fork
            begin
                for (int k = 0; k < 8; k++) send_up(k % 3, 1 + k % 5, k % 4, 1 + k % 3, 20 + k, "R2 mixed up");
            end
            begin
                for (int k = 0; k < 7; k++) send_inj(k % 3, k, 1 + k % 5, k % 3, 40 + k, "R2 mixed inj");
            end
        join
        bp_en = 1'b0;
        repeat (30) @(negedge clk);

        log_on = 1'b1;                                    // R10 fairness
        fork
            begin for (int k = 0; k < 4; k++) send_up(0, 1, 0, 2, 60 + k, "R10 up"); end
            begin for (int k = 0; k < 4; k++) send_inj(0, 0, 1, 2, 70 + k, "R10 inj"); end
        join
        repeat (30) @(negedge clk);
        log_on = 1'b0;
        check(src_log.size() == 8, "R10 event count", W'(src_log.size()), W'(8));
        for (int i = 1; i < src_log.size(); i++)
            check(src_log[i] != src_log[i-1], "R10 alternation", W'(src_log[i]), W'(1 - src_log[i-1]));

        check(q_dn_up.size() == 0,  "R2 dn upstream drained",  W'(q_dn_up.size()), W'(0));
        check(q_dn_inj.size() == 0, "R2 dn injected drained",  W'(q_dn_inj.size()), W'(0));
        check(q_loc.size() == 0,    "R2 local drained",        W'(q_loc.size()), W'(0));
        finish_run();
    end

endmodule